// File: doc/BRIEF.md
# Floating-Point Compare Unit with Condition Status

The block compares two IEEE-754 operands and records the outcome in a small floating-point status register. A precision input picks either single precision, taken from the low 32 bits of each operand bus, or double precision, taken from the full 64 bits. Both widths follow the same rules. Before the ordering decision, each operand is classified as zero, signalling NaN, quiet NaN or a number. Denormal encodings count as zero of the same sign.

A one-cycle `start` strobe launches a compare. On the next clock edge the status register is updated and `done` pulses high. The register has three groups of bits:

- Cause bits [4:0]: inexact 0, underflow 1, overflow 2, divide-by-zero 3, invalid 4.
- Enable bits [9:5]: the same order, so the invalid enable is bit 9.
- Condition flags [13:10]: less 10, equal 11, greater 12, unordered 13.

Software loads the register through a plain write port and reads it back continuously. When a compare records the invalid cause, a one-cycle trap request leaves the block together with the fixed exception code 0x1D0. No data stream crosses the block edge. `start`, `done` and `trap` are plain strobes with no back-pressure: a compare can be issued on every cycle.

Top module: `fpcmp_unit`

## Requirements
- R1: After a clock edge with `rst_n` low, `csr_rdata` is 0 and `done` and `trap` are 0.
- R2: With `start` low, a cycle with `csr_we` high loads `csr_wdata` into the register, and the value is visible on `csr_rdata` after that edge.
- R3: A compare clears all five cause bits and all four condition flags before setting its result. The enable bits [9:5] are left unchanged.
- R4: `done` is high for exactly the cycle after each cycle with `start` high, and the register shows the result in that same cycle. Back-to-back starts produce back-to-back results.
- R5: For single-precision non-NaN operands, exactly one of less (bit 10), equal (bit 11) or greater (bit 12) is set. The comparison is `op_a` against `op_b` in sign-magnitude order, so two negative values order by reversed magnitude, and infinities order beyond all finite values.
- R6: With `dbl` high, the 64-bit encodings are compared by the same rules. With `dbl` low, bits [63:32] of both operands have no effect on the result.
- R7: An operand whose exponent field is all zeros is treated as zero of its own sign. Positive zero and negative zero compare equal.
- R8: When no operand is a signalling NaN and at least one is a quiet NaN (exponent all ones, mantissa MSB 1), only unordered (bit 13) is set and no cause bit is set.
- R9: When either operand is a signalling NaN (exponent all ones, mantissa MSB 0, mantissa non-zero) and the invalid enable (bit 9) is 1, only the invalid cause (bit 4) is set and all four flags stay clear.
- R10: When either operand is a signalling NaN and the invalid enable is 0, unordered (bit 13) is set and no cause bit is set.
- R11: `trap` pulses in the `done` cycle exactly when the compare set a cause bit, with `trap_code` equal to 0x1D0. A compare that only sets a flag raises no trap.
- R12: A register write in the same cycle as `start` is dropped, and the compare result is what gets stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a compare this cycle |
| dbl | input | 1 | 1 = double precision, 0 = single precision (low 32 bits) |
| op_a | input | 64 | First operand encoding |
| op_b | input | 64 | Second operand encoding |
| csr_we | input | 1 | Status register write strobe |
| csr_wdata | input | 14 | Status register write data |
| csr_rdata | output | 14 | Status register contents |
| done | output | 1 | Result-valid pulse, one cycle after `start` |
| trap | output | 1 | Exception trap request pulse |
| trap_code | output | 12 | Exception code carried with the trap (0x1D0) |

## Verification
The embedded assertions watch every cycle for the following properties:
- Each start is followed by `done`.
- A finished compare leaves exactly one of the four flags or the invalid cause set.
- The other cause bits are cleared.
- The enables survive a compare.
- `trap` appears only with `done` and matches the invalid cause.

Only the bench scenarios, with their expected values, can show the following:
- The actual ordering decision: negative operands, infinities, flushed denormals and equal signed zeros.
- That the upper operand bits are ignored in single precision.
- That a write colliding with a start is lost.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;
  localparam int N_EXC     = 5;
  localparam int N_FLAG    = 4;
  localparam int CAUSE_LSB = 0;
  localparam int ENA_LSB   = CAUSE_LSB + N_EXC;
  localparam int FLAG_LSB  = ENA_LSB + N_EXC;
  localparam int CSR_W     = FLAG_LSB + N_FLAG;
  localparam int EXC_INV   = 4;
  localparam int FLG_LT    = 0;
  localparam int FLG_EQ    = 1;
  localparam int FLG_GT    = 2;
  localparam int FLG_UN    = 3;
  localparam int DBL_W     = 64;
  localparam int SGL_W     = 32;
  localparam int MAG_W     = DBL_W - 1;

  typedef struct packed {
    logic             sign;
    logic             zero;
    logic             snan;
    logic             qnan;
    logic [MAG_W-1:0] mag;
  } fp_class_t;
endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify
  import fpcmp_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] word,
  output fp_class_t            cls
);
  localparam int W = EXP_W + MAN_W + 1;

  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;
  logic             exp_max, exp_nil;

  assign exp_f   = word[W-2 -: EXP_W];
  assign man_f   = word[MAN_W-1:0];
  assign exp_max = &exp_f;
  assign exp_nil = ~|exp_f;

  assign cls.sign = word[W-1];
  // denormals flushed: a zero exponent means zero regardless of mantissa
  assign cls.zero = exp_nil;
  assign cls.snan = exp_max & (|man_f) & ~man_f[MAN_W-1];
  assign cls.qnan = exp_max & man_f[MAN_W-1];
  assign cls.mag  = exp_nil ? '0 : MAG_W'({exp_f, man_f});
endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order
  import fpcmp_pkg::*;
(
  input  logic             a_sign,
  input  logic             a_zero,
  input  logic [MAG_W-1:0] a_mag,
  input  logic             b_sign,
  input  logic             b_zero,
  input  logic [MAG_W-1:0] b_mag,
  output logic             lt,
  output logic             eq,
  output logic             gt
);
  logic sa, sb;

  // zeros of either sign are treated as positive so that +0 == -0
  assign sa = a_sign & ~a_zero;
  assign sb = b_sign & ~b_zero;

  always_comb begin
    eq = (sa == sb) && (a_mag == b_mag);
    if (sa != sb) gt = sb;
    else if (sa)  gt = a_mag < b_mag;
    else          gt = a_mag > b_mag;
    gt = gt & ~eq;
    lt = ~eq & ~gt;
  end
endmodule

// File: rtl/fpcmp_unit.sv
module fpcmp_unit
  import fpcmp_pkg::*;
#(
  parameter int          CODE_W    = 12,
  parameter logic [11:0] TRAP_CODE = 12'h1D0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             dbl,
  input  logic [DBL_W-1:0] op_a,
  input  logic [DBL_W-1:0] op_b,
  input  logic             csr_we,
  input  logic [CSR_W-1:0] csr_wdata,
  output logic [CSR_W-1:0] csr_rdata,
  output logic             done,
  output logic             trap,
  output logic [CODE_W-1:0] trap_code
);
  logic [DBL_W-1:0] ops [2];
  fp_class_t        cls_s [2];
  fp_class_t        cls_d [2];
  fp_class_t        cls   [2];

  assign ops[0] = op_a;
  assign ops[1] = op_b;

  for (genvar k = 0; k < 2; k++) begin : g_opnd
    fpcmp_classify #(.EXP_W(8), .MAN_W(23)) u_sgl (
      .word(ops[k][SGL_W-1:0]), .cls(cls_s[k]));
    fpcmp_classify #(.EXP_W(11), .MAN_W(52)) u_dbl (
      .word(ops[k]), .cls(cls_d[k]));
    assign cls[k] = dbl ? cls_d[k] : cls_s[k];
  end

  logic lt, eq, gt;

  fpcmp_order u_order (
    .a_sign(cls[0].sign), .a_zero(cls[0].zero), .a_mag(cls[0].mag),
    .b_sign(cls[1].sign), .b_zero(cls[1].zero), .b_mag(cls[1].mag),
    .lt(lt), .eq(eq), .gt(gt));

  logic [CSR_W-1:0]  csr_q, csr_d;
  logic              done_q, trap_q;
  logic              any_snan, any_qnan, inv_en;
  logic [N_FLAG-1:0] flags_n;
  logic [N_EXC-1:0]  cause_n;

  assign any_snan = cls[0].snan | cls[1].snan;
  assign any_qnan = cls[0].qnan | cls[1].qnan;
  assign inv_en   = csr_q[ENA_LSB + EXC_INV];

  always_comb begin
    flags_n = '0;
    cause_n = '0;
    if (any_snan) begin
      if (inv_en) cause_n[EXC_INV] = 1'b1;
      else        flags_n[FLG_UN]  = 1'b1;
    end else if (any_qnan) begin
      flags_n[FLG_UN] = 1'b1;
    end else begin
      flags_n[FLG_LT] = lt;
      flags_n[FLG_EQ] = eq;
      flags_n[FLG_GT] = gt;
    end
  end

  always_comb begin
    csr_d = csr_q;
    if (start) begin
      csr_d[FLAG_LSB +: N_FLAG]  = flags_n;
      csr_d[CAUSE_LSB +: N_EXC]  = cause_n;
    end else if (csr_we) begin
      csr_d = csr_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      csr_q  <= '0;
      done_q <= 1'b0;
      trap_q <= 1'b0;
    end else begin
      csr_q  <= csr_d;
      done_q <= start;
      trap_q <= start & (|cause_n);
    end
  end

  assign csr_rdata = csr_q;
  assign done      = done_q;
  assign trap      = trap_q;
  assign trap_code = CODE_W'(TRAP_CODE);

  // R4
  done_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);
  // R5
  single_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $countones({csr_q[FLAG_LSB +: N_FLAG], csr_q[CAUSE_LSB + EXC_INV]}) == 1);
  // R3
  enables_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> csr_q[ENA_LSB +: N_EXC] == $past(csr_q[ENA_LSB +: N_EXC]));
  // R3
  other_causes_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> csr_q[CAUSE_LSB +: EXC_INV] == '0);
  // R11
  trap_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> done);
  // R11
  trap_matches_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> trap == csr_q[CAUSE_LSB + EXC_INV]);
  // R8
  qnan_unordered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !any_snan && any_qnan) |=> (csr_q[FLAG_LSB + FLG_UN] && !trap));
endmodule

// File: tb/test_fpcmp_unit.sv
module test_fpcmp_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        dbl = 1'b0;
  logic [63:0] op_a = '0, op_b = '0;
  logic        csr_we = 1'b0;
  logic [13:0] csr_wdata = '0;
  logic [13:0] csr_rdata;
  logic        done, trap;
  logic [11:0] trap_code;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  fpcmp_unit i_fpcmp_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .dbl(dbl),
    .op_a(op_a), .op_b(op_b), .csr_we(csr_we), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .done(done), .trap(trap), .trap_code(trap_code));

  // ---------------- reference model ----------------
  logic [13:0] m_csr = '0;
  logic        m_done = 1'b0, m_trap = 1'b0;

  function automatic bit is_nan(logic [63:0] x, bit d);
    if (d) return (x[62:52] == 11'h7ff) && (x[51:0] != 0);
    return (x[30:23] == 8'hff) && (x[22:0] != 0);
  endfunction

  function automatic bit is_quiet(logic [63:0] x, bit d);
    return d ? x[51] : x[22];
  endfunction

  function automatic real to_real(logic [63:0] x, bit d);
    logic [10:0] de;
    if (d) begin
      if (x[62:52] == 0) return 0.0;
      return $bitstoreal(x);
    end
    if (x[30:23] == 0) return 0.0;
    de = (x[30:23] == 8'hff) ? 11'h7ff : 11'(x[30:23]) + 11'd896;
    return $bitstoreal({x[31], de, x[22:0], 29'b0});
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_csr <= '0; m_done <= 1'b0; m_trap <= 1'b0;
    end else begin
      m_done <= start;
      m_trap <= 1'b0;
      if (start) begin
        logic [13:0] n;
        bit sn, qn;
        real ra, rb;
        n  = {4'b0, m_csr[9:5], 5'b0};
        sn = (is_nan(op_a, dbl) && !is_quiet(op_a, dbl)) ||
             (is_nan(op_b, dbl) && !is_quiet(op_b, dbl));
        qn = is_nan(op_a, dbl) || is_nan(op_b, dbl);
        if (sn) begin
          if (m_csr[9]) begin n[4] = 1'b1; m_trap <= 1'b1; end
          else n[13] = 1'b1;
        end else if (qn) n[13] = 1'b1;
        else begin
          ra = to_real(op_a, dbl);
          rb = to_real(op_b, dbl);
          if (ra < rb) n[10] = 1'b1;
          else if (ra > rb) n[12] = 1'b1;
          else n[11] = 1'b1;
        end
        m_csr <= n;
      end else if (csr_we) m_csr <= csr_wdata;
    end
  end

  always @(negedge clk) begin
    checks++;
    if (csr_rdata !== m_csr) begin
      errors++;
      $display("FAIL %s csr_rdata actual %h expected %h", cur_req, csr_rdata, m_csr);
    end
    checks++;
    if (done !== m_done) begin
      errors++;
      $display("FAIL %s done actual %b expected %b", cur_req, done, m_done);
    end
    checks++;
    if (trap !== m_trap) begin
      errors++;
      $display("FAIL %s trap actual %b expected %b", cur_req, trap, m_trap);
    end
    if (trap === 1'b1) begin
      checks++;
      if (trap_code !== 12'h1D0) begin
        errors++;
        $display("FAIL R11 trap_code actual %h expected 1d0", trap_code);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic cmp(input logic [63:0] a, input logic [63:0] b, input bit d);
    op_a = a; op_b = b; dbl = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [13:0] v);
    csr_we = 1'b1; csr_wdata = v;
    @(negedge clk);
    csr_we = 1'b0;
    @(negedge clk);
  endtask

  localparam logic [63:0] S_P1 = 64'h3F800000, S_P2 = 64'h40000000;
  localparam logic [63:0] S_N1 = 64'hBF800000, S_N2 = 64'hC0000000;
  localparam logic [63:0] S_PI = 64'h7F800000, S_NI = 64'hFF800000;
  localparam logic [63:0] S_QN = 64'h7FC00000, S_SN = 64'h7F800001;
  localparam logic [63:0] S_DN = 64'h00000001, S_ND = 64'h80000001;
  localparam logic [63:0] S_NZ = 64'h80000000, S_MIN = 64'h00800000;
  localparam logic [63:0] D_P1 = 64'h3FF0000000000000, D_P2 = 64'h4000000000000000;
  localparam logic [63:0] D_N2 = 64'hC000000000000000, D_QN = 64'h7FF8000000000000;
  localparam logic [63:0] D_SN = 64'h7FF0000000000001, D_DN = 64'h0000000000000001;

  initial begin
    @(negedge clk); @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R2";
    wr(14'h3FFF); wr(14'h0000); wr(14'h0155);
    cur_req = "R3";
    wr(14'h3C1F);
    cmp(S_P1, S_P2, 0);
    cur_req = "R5";
    cmp(S_P1, S_P2, 0); cmp(S_P2, S_P1, 0); cmp(S_P1, S_P1, 0);
    cmp(S_N1, S_N2, 0); cmp(S_N2, S_N1, 0); cmp(S_N1, S_P1, 0);
    cmp(S_PI, S_P2, 0); cmp(S_NI, S_N2, 0);
    cur_req = "R6";
    cmp(D_P1, D_P2, 1); cmp(D_N2, D_P1, 1); cmp(D_P2, D_P2, 1);
    cmp({32'hDEADBEEF, S_P1[31:0]}, S_P1, 0);
    cmp({32'h7FFFFFFF, S_P1[31:0]}, {32'h00000001, S_P2[31:0]}, 0);
    cur_req = "R7";
    cmp(S_DN, 64'h0, 0); cmp(S_ND, 64'h0, 0); cmp(S_NZ, 64'h0, 0);
    cmp(S_DN, S_MIN, 0); cmp(S_ND, S_P1, 0); cmp(D_DN, 64'h0, 1);
    cur_req = "R8";
    cmp(S_QN, S_P1, 0); cmp(D_P1, D_QN, 1);
    cur_req = "R10";
    cmp(S_SN, S_P1, 0); cmp(S_QN, S_SN, 0); cmp(D_P1, D_SN, 1);
    cur_req = "R9";
    wr(14'h0200);
    cmp(S_SN, S_P1, 0); cmp(D_QN, D_SN, 1);
    cur_req = "R11";
    cmp(S_P1, S_P2, 0);
    wr(14'h03E0);
    cmp(S_QN, S_P1, 0); cmp(S_SN, S_SN, 0);
    cur_req = "R12";
    wr(14'h0200);
    op_a = S_SN; op_b = S_P1; dbl = 0; start = 1'b1;
    csr_we = 1'b1; csr_wdata = 14'h0000;
    @(negedge clk);
    start = 1'b0; csr_we = 1'b0;
    @(negedge clk);
    cur_req = "R4";
    op_a = S_P1; op_b = S_P2; dbl = 0; start = 1'b1;
    @(negedge clk);
    op_a = S_SN;
    @(negedge clk);
    op_a = S_P2; op_b = S_P1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk); @(negedge clk);
    cur_req = "R1";
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule